// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block works out where a byte-oriented processor with a 16-bit program space fetches next. For each instruction it takes the current program counter, the instruction's length and a branch kind. It also takes every operand a branch could use: a long absolute address, an in-page address, a signed 8-bit displacement, the accumulator, a 16-bit data pointer, and the condition sources. From these it produces the next program counter and a taken flag.

All target forms are measured from the address of the following instruction, which is the current PC plus the length, wrapping at 64 KB. The in-page form keeps the upper address bits of that following address. The relative form adds a sign-extended displacement to it. The indirect form adds the accumulator to the data pointer.

For compare-and-branch the unit also returns an unsigned less-than carry. For decrement-and-branch it returns the decremented byte. For calls it streams the return address out one byte per cycle, low byte first, so that a stack writer can push it. Fetch, decode and the stack memory sit outside the block. Results are registered and appear one cycle after a request.

Top module: `pc_next_unit`

## Requirements
- R1: While reset is high and directly after it, `out_valid`, `taken`, `call_out`, `push_valid` and `next_pc` are all zero.
- R2: The following address is `(cur_pc + instr_len) mod 65536`. Kind 0 (sequential), kind 15 (reserved) and every conditional kind whose condition is false give `next_pc` equal to it with `taken` = 0.
- R3: Kinds 1 (long jump) and 5 (long call) give `next_pc` = `abs_addr` with `taken` = 1.
- R4: Kinds 2 (page jump) and 6 (page call) give `next_pc` = {following address bits 15..11, `page_addr`}, with `taken` = 1.
- R5: Kind 3 (short jump) and every taken conditional give `next_pc` = following address + sign-extended `rel_off`, modulo 65536.
- R6: Kind 4 (indirect jump) gives `next_pc` = (`acc` + `dptr`) mod 65536 with `taken` = 1.
- R7: The condition for kinds 7 to 12 is, in order: `acc` == 0, `acc` != 0, `carry_in`, !`carry_in`, `bit_in`, !`bit_in`.
- R8: Kind 13 (compare) is taken when `cmp_a` != `cmp_b` and sets `cmp_carry` = (`cmp_a` < `cmp_b`) unsigned. Every other kind gives `cmp_carry` = 0.
- R9: Kind 14 (decrement) sets `dec_out` = (`dec_src` − 1) mod 256 and is taken when that value is nonzero. Every other kind gives `dec_out` = 0.
- R10: Kinds 5 and 6 raise `call_out`. `push_valid` is then high for two consecutive cycles: the first in step with `out_valid`, carrying the following address low byte, and the second carrying its high byte. Calls must be issued at least two cycles apart.
- R11: `out_valid` is high in exactly the cycle after a cycle with `req_valid` high. With no request it is low and the other result outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; inputs sampled on this edge |
| cur_pc | input | 16 | Address of the current instruction |
| instr_len | input | 2 | Instruction length in bytes (1 to 3) |
| br_kind | input | 4 | Branch kind code (see requirements) |
| page_addr | input | 11 | In-page target bits |
| abs_addr | input | 16 | Long absolute target |
| rel_off | input | 8 | Signed displacement |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| carry_in | input | 1 | Carry flag |
| bit_in | input | 1 | Value of the tested bit |
| cmp_a | input | 8 | First compare operand |
| cmp_b | input | 8 | Second compare operand |
| dec_src | input | 8 | Byte before decrement |
| out_valid | output | 1 | Results valid |
| next_pc | output | 16 | Next program counter |
| taken | output | 1 | Branch taken |
| call_out | output | 1 | Instruction was a call |
| cmp_carry | output | 1 | Unsigned less-than from compare |
| dec_out | output | 8 | Decremented byte |
| push_valid | output | 1 | Return-address byte valid |
| push_byte | output | 8 | Return-address byte, low first |

## Verification
A request captured on a rising edge shows up in every result output, and in the low return byte, after that same edge. The high return byte is due one edge later, and `push_valid` falls on the edge after that. The bench drives inputs on falling edges and reads results on the next falling edge. For calls it reads two more falling edges to see the high byte and then the idle push line. A separate per-clock comparison holds `out_valid` against a one-cycle delayed copy of the request strobe.

// File: rtl/pnu_pkg.sv
package pnu_pkg;

    typedef enum logic [3:0] {
        BK_SEQ       = 4'd0,
        BK_JMP_LONG  = 4'd1,
        BK_JMP_PAGE  = 4'd2,
        BK_JMP_REL   = 4'd3,
        BK_JMP_IND   = 4'd4,
        BK_CALL_LONG = 4'd5,
        BK_CALL_PAGE = 4'd6,
        BK_IF_AZ     = 4'd7,
        BK_IF_ANZ    = 4'd8,
        BK_IF_C      = 4'd9,
        BK_IF_NC     = 4'd10,
        BK_IF_B      = 4'd11,
        BK_IF_NB     = 4'd12,
        BK_IF_CMPNE  = 4'd13,
        BK_IF_DECNZ  = 4'd14,
        BK_RSVD      = 4'd15
    } br_kind_e;

    typedef enum logic [2:0] {
        TG_FOLLOW,
        TG_ABS,
        TG_PAGE,
        TG_REL,
        TG_IND
    } tgt_sel_e;

    typedef enum logic [3:0] {
        CD_NEVER,
        CD_ALWAYS,
        CD_AZ,
        CD_ANZ,
        CD_C,
        CD_NC,
        CD_B,
        CD_NB,
        CD_NE,
        CD_DNZ
    } cond_sel_e;

    typedef struct packed {
        tgt_sel_e  tgt;
        cond_sel_e cnd;
        logic      call;
    } kind_info_t;

    function automatic kind_info_t decode_kind(input br_kind_e k);
        kind_info_t d;
        d.tgt  = TG_FOLLOW;
        d.cnd  = CD_NEVER;
        d.call = 1'b0;
        case (k)
            BK_JMP_LONG:  begin d.tgt = TG_ABS;  d.cnd = CD_ALWAYS; end
            BK_JMP_PAGE:  begin d.tgt = TG_PAGE; d.cnd = CD_ALWAYS; end
            BK_JMP_REL:   begin d.tgt = TG_REL;  d.cnd = CD_ALWAYS; end
            BK_JMP_IND:   begin d.tgt = TG_IND;  d.cnd = CD_ALWAYS; end
            BK_CALL_LONG: begin d.tgt = TG_ABS;  d.cnd = CD_ALWAYS; d.call = 1'b1; end
            BK_CALL_PAGE: begin d.tgt = TG_PAGE; d.cnd = CD_ALWAYS; d.call = 1'b1; end
            BK_IF_AZ:     begin d.tgt = TG_REL;  d.cnd = CD_AZ;  end
            BK_IF_ANZ:    begin d.tgt = TG_REL;  d.cnd = CD_ANZ; end
            BK_IF_C:      begin d.tgt = TG_REL;  d.cnd = CD_C;   end
            BK_IF_NC:     begin d.tgt = TG_REL;  d.cnd = CD_NC;  end
            BK_IF_B:      begin d.tgt = TG_REL;  d.cnd = CD_B;   end
            BK_IF_NB:     begin d.tgt = TG_REL;  d.cnd = CD_NB;  end
            BK_IF_CMPNE:  begin d.tgt = TG_REL;  d.cnd = CD_NE;  end
            BK_IF_DECNZ:  begin d.tgt = TG_REL;  d.cnd = CD_DNZ; end
            default:      begin d.tgt = TG_FOLLOW; d.cnd = CD_NEVER; end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pnu_target.sv
module pnu_target #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 11,
    parameter int OFF_W  = 8,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2
) (
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [LEN_W-1:0]  instr_len,
    input  logic [PAGE_W-1:0] page_addr,
    input  logic [ADDR_W-1:0] abs_addr,
    input  logic [OFF_W-1:0]  rel_off,
    input  logic [DATA_W-1:0] acc,
    input  logic [ADDR_W-1:0] dptr,
    input  pnu_pkg::tgt_sel_e sel,
    output logic [ADDR_W-1:0] follow,
    output logic [ADDR_W-1:0] target
);
    localparam int HI_W  = ADDR_W - PAGE_W;
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] t_page;
    logic [ADDR_W-1:0] t_rel;
    logic [ADDR_W-1:0] t_ind;
    logic [ADDR_W-1:0] off_ext;

    assign follow  = cur_pc + ADDR_W'(instr_len);
    assign off_ext = {{EXT_W{rel_off[OFF_W-1]}}, rel_off};
    assign t_rel   = follow + off_ext;
    assign t_ind   = ADDR_W'(acc) + dptr;

    generate
        if (HI_W > 0) begin : g_paged
            assign t_page = {follow[ADDR_W-1:PAGE_W], page_addr};
        end else begin : g_flat
            assign t_page = page_addr[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        case (sel)
            pnu_pkg::TG_ABS:  target = abs_addr;
            pnu_pkg::TG_PAGE: target = t_page;
            pnu_pkg::TG_REL:  target = t_rel;
            pnu_pkg::TG_IND:  target = t_ind;
            default:          target = follow;
        endcase
    end
endmodule

// File: rtl/pnu_cond.sv
module pnu_cond #(
    parameter int DATA_W = 8
) (
    input  pnu_pkg::cond_sel_e cnd,
    input  logic [DATA_W-1:0]  acc,
    input  logic               carry_in,
    input  logic               bit_in,
    input  logic [DATA_W-1:0]  cmp_a,
    input  logic [DATA_W-1:0]  cmp_b,
    input  logic [DATA_W-1:0]  dec_src,
    output logic               hit,
    output logic               lt,
    output logic [DATA_W-1:0]  dec_val
);
    logic acc_zero;
    logic [DATA_W-1:0] dec_raw;

    assign acc_zero = (acc == '0);
    assign dec_raw  = dec_src - DATA_W'(1);

    always_comb begin
        lt      = 1'b0;
        dec_val = '0;
        case (cnd)
            pnu_pkg::CD_ALWAYS: hit = 1'b1;
            pnu_pkg::CD_AZ:     hit = acc_zero;
            pnu_pkg::CD_ANZ:    hit = !acc_zero;
            pnu_pkg::CD_C:      hit = carry_in;
            pnu_pkg::CD_NC:     hit = !carry_in;
            pnu_pkg::CD_B:      hit = bit_in;
            pnu_pkg::CD_NB:     hit = !bit_in;
            pnu_pkg::CD_NE: begin
                hit = (cmp_a != cmp_b);
                lt  = (cmp_a < cmp_b);
            end
            pnu_pkg::CD_DNZ: begin
                hit     = (dec_raw != '0);
                dec_val = dec_raw;
            end
            default:            hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/pnu_push.sv
module pnu_push #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] ret_addr,
    output logic              push_valid,
    output logic [7:0]        push_byte
);
    localparam int NB   = (ADDR_W + 7) / 8;
    localparam int SH_W = NB * 8;
    localparam int CW   = $clog2(NB + 1);

    logic [SH_W-1:0] shreg;
    logic [CW-1:0]   left;
    logic [SH_W-1:0] ret_pad;

    assign ret_pad = SH_W'(ret_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg      <= '0;
            left       <= '0;
            push_valid <= 1'b0;
            push_byte  <= '0;
        end else if (start) begin
            push_valid <= 1'b1;
            push_byte  <= ret_pad[7:0];
            shreg      <= ret_pad >> 8;
            left       <= CW'(NB - 1);
        end else if (left != '0) begin
            push_valid <= 1'b1;
            push_byte  <= shreg[7:0];
            shreg      <= shreg >> 8;
            left       <= left - CW'(1);
        end else begin
            push_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 11,
    parameter int OFF_W  = 8,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [LEN_W-1:0]  instr_len,
    input  logic [3:0]        br_kind,
    input  logic [PAGE_W-1:0] page_addr,
    input  logic [ADDR_W-1:0] abs_addr,
    input  logic [OFF_W-1:0]  rel_off,
    input  logic [DATA_W-1:0] acc,
    input  logic [ADDR_W-1:0] dptr,
    input  logic              carry_in,
    input  logic              bit_in,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic [DATA_W-1:0] dec_src,
    output logic              out_valid,
    output logic [ADDR_W-1:0] next_pc,
    output logic              taken,
    output logic              call_out,
    output logic              cmp_carry,
    output logic [DATA_W-1:0] dec_out,
    output logic              push_valid,
    output logic [7:0]        push_byte
);
    import pnu_pkg::*;

    kind_info_t        info;
    logic [ADDR_W-1:0] follow;
    logic [ADDR_W-1:0] target;
    logic              hit;
    logic              lt;
    logic [DATA_W-1:0] dec_val;
    logic              call_start;

    assign info = decode_kind(br_kind_e'(br_kind));

    pnu_target #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W),
        .DATA_W(DATA_W), .LEN_W(LEN_W)
    ) tgt_i (
        .cur_pc    (cur_pc),
        .instr_len (instr_len),
        .page_addr (page_addr),
        .abs_addr  (abs_addr),
        .rel_off   (rel_off),
        .acc       (acc),
        .dptr      (dptr),
        .sel       (info.tgt),
        .follow    (follow),
        .target    (target)
    );

    pnu_cond #(.DATA_W(DATA_W)) cond_i (
        .cnd      (info.cnd),
        .acc      (acc),
        .carry_in (carry_in),
        .bit_in   (bit_in),
        .cmp_a    (cmp_a),
        .cmp_b    (cmp_b),
        .dec_src  (dec_src),
        .hit      (hit),
        .lt       (lt),
        .dec_val  (dec_val)
    );

    assign call_start = req_valid && info.call;

    pnu_push #(.ADDR_W(ADDR_W)) push_i (
        .clk        (clk),
        .rst        (rst),
        .start      (call_start),
        .ret_addr   (follow),
        .push_valid (push_valid),
        .push_byte  (push_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            next_pc   <= '0;
            taken     <= 1'b0;
            call_out  <= 1'b0;
            cmp_carry <= 1'b0;
            dec_out   <= '0;
        end else if (req_valid) begin
            out_valid <= 1'b1;
            next_pc   <= hit ? target : follow;
            taken     <= hit;
            call_out  <= info.call;
            cmp_carry <= lt;
            dec_out   <= dec_val;
        end else begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/pc_next_unit_chk.sv
module pc_next_unit_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [3:0]        br_kind,
    input logic [ADDR_W-1:0] abs_addr,
    input logic [DATA_W-1:0] acc,
    input logic [ADDR_W-1:0] dptr,
    input logic [DATA_W-1:0] cmp_a,
    input logic [DATA_W-1:0] cmp_b,
    input logic              out_valid,
    input logic [ADDR_W-1:0] next_pc,
    input logic              taken,
    input logic              call_out,
    input logic              cmp_carry,
    input logic              push_valid
);
    p_latency_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);

    p_seq_untaken_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && br_kind == 4'd0) |=> !taken);

    p_long_target_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && br_kind == 4'd1) |=> (taken && next_pc == $past(abs_addr)));

    p_indirect_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && br_kind == 4'd4) |=>
            (next_pc == ADDR_W'($past(acc)) + $past(dptr)));

    p_compare_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && br_kind == 4'd13) |=>
            (cmp_carry == ($past(cmp_a) < $past(cmp_b)) &&
             taken == ($past(cmp_a) != $past(cmp_b))));

    p_push_first_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && call_out) |-> push_valid);

    p_push_second_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && call_out) |=> push_valid);
endmodule

bind pc_next_unit pc_next_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .br_kind    (br_kind),
    .abs_addr   (abs_addr),
    .acc        (acc),
    .dptr       (dptr),
    .cmp_a      (cmp_a),
    .cmp_b      (cmp_b),
    .out_valid  (out_valid),
    .next_pc    (next_pc),
    .taken      (taken),
    .call_out   (call_out),
    .cmp_carry  (cmp_carry),
    .push_valid (push_valid)
);

// File: tb/pc_next_unit_tb_top.sv
module pc_next_unit_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] cur_pc = '0;
    logic [1:0]  instr_len = 2'd1;
    logic [3:0]  br_kind = '0;
    logic [10:0] page_addr = '0;
    logic [15:0] abs_addr = '0;
    logic [7:0]  rel_off = '0;
    logic [7:0]  acc = '0;
    logic [15:0] dptr = '0;
    logic        carry_in = 1'b0;
    logic        bit_in = 1'b0;
    logic [7:0]  cmp_a = '0;
    logic [7:0]  cmp_b = '0;
    logic [7:0]  dec_src = '0;
    logic        out_valid;
    logic [15:0] next_pc;
    logic        taken;
    logic        call_out;
    logic        cmp_carry;
    logic [7:0]  dec_out;
    logic        push_valid;
    logic [7:0]  push_byte;

    int checks = 0;
    int fails  = 0;
    logic exp_v = 1'b0;
    bit   live  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pc_next_unit dut_i (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock model of the valid strobe (R11)
    always @(posedge clk) exp_v <= rst ? 1'b0 : req_valid;
    always @(negedge clk) if (live && !rst)
        chk(out_valid == exp_v, "R11 out_valid", int'(out_valid), int'(exp_v));

    task automatic go(input string req);
        int follow, tgt, ex_next, ex_cc, ex_dec, soff, dv;
        bit tk, is_call;
        follow = (int'(cur_pc) + int'(instr_len)) & 16'hFFFF;
        soff   = (rel_off >= 8'd128) ? int'(rel_off) - 256 : int'(rel_off);
        dv     = (int'(dec_src) - 1) & 8'hFF;
        tk = 1'b0; tgt = follow; ex_cc = 0; ex_dec = 0;
        is_call = (br_kind == 4'd5) || (br_kind == 4'd6);
        case (br_kind)
            4'd1, 4'd5: begin tk = 1; tgt = int'(abs_addr); end
            4'd2, 4'd6: begin tk = 1; tgt = (follow & 16'hF800) | int'(page_addr); end
            4'd4:       begin tk = 1; tgt = (int'(acc) + int'(dptr)) & 16'hFFFF; end
            default:    tgt = (follow + soff) & 16'hFFFF;
        endcase
        case (br_kind)
            4'd3:  tk = 1;
            4'd7:  tk = (acc == 0);
            4'd8:  tk = (acc != 0);
            4'd9:  tk = carry_in;
            4'd10: tk = !carry_in;
            4'd11: tk = bit_in;
            4'd12: tk = !bit_in;
            4'd13: begin tk = (cmp_a != cmp_b); ex_cc = int'(cmp_a < cmp_b); end
            4'd14: begin tk = (dv != 0); ex_dec = dv; end
            default: ;
        endcase
        ex_next = tk ? tgt : follow;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(int'(next_pc) == ex_next, {req, " next_pc"}, int'(next_pc), ex_next);
        chk(taken == tk, {req, " taken"}, int'(taken), int'(tk));
        chk(cmp_carry == ex_cc[0], {req, " R8 cmp_carry"}, int'(cmp_carry), ex_cc);
        chk(int'(dec_out) == ex_dec, {req, " R9 dec_out"}, int'(dec_out), ex_dec);
        chk(call_out == is_call, {req, " R10 call_out"}, int'(call_out), int'(is_call));
        if (is_call) begin
            chk(push_valid && int'(push_byte) == (follow & 8'hFF), "R10 push low",
                int'(push_byte), follow & 8'hFF);
            @(negedge clk);
            chk(push_valid && int'(push_byte) == (follow >> 8), "R10 push high",
                int'(push_byte), follow >> 8);
            @(negedge clk);
            chk(!push_valid, "R10 push done", int'(push_valid), 0);
        end else begin
            chk(!push_valid, {req, " R10 no push"}, int'(push_valid), 0);
        end
    endtask

    initial begin
        #(CLK_P * 20000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!out_valid && !taken && !push_valid && next_pc == 0 && !call_out,
            "R1 reset state", int'(next_pc), 0);
        rst = 1'b0;
        @(negedge clk);
        live = 1'b1;
        chk(!out_valid && next_pc == 0, "R1 after reset", int'(out_valid), 0);

        // R2 sequential, lengths 1..3 and wrap
        cur_pc = 16'h1234; instr_len = 2'd1; br_kind = 4'd0; go("R2 seq len1");
        cur_pc = 16'hFFFE; instr_len = 2'd3; go("R2 seq wrap");
        br_kind = 4'd15; instr_len = 2'd2; cur_pc = 16'h0100; go("R2 reserved");
        // R11 hold with no request
        @(negedge clk);
        chk(next_pc == 16'h0102, "R11 hold", int'(next_pc), 16'h0102);
        // R3 long jump
        br_kind = 4'd1; abs_addr = 16'hBEEF; cur_pc = 16'h0010; instr_len = 2'd3; go("R3 long");
        // R4 page, crossing into next page via following address
        br_kind = 4'd2; cur_pc = 16'h07FE; instr_len = 2'd2; page_addr = 11'h123; go("R4 page cross");
        cur_pc = 16'hF9F0; page_addr = 11'h7FF; go("R4 page high");
        // R5 relative forward, backward, wrap
        br_kind = 4'd3; cur_pc = 16'h2000; instr_len = 2'd2; rel_off = 8'h7F; go("R5 rel fwd");
        rel_off = 8'h80; go("R5 rel back");
        cur_pc = 16'hFFFE; instr_len = 2'd3; rel_off = 8'h80; go("R5 rel wrap");
        cur_pc = 16'hFFF0; instr_len = 2'd2; rel_off = 8'h20; go("R5 rel wrap up");
        // R6 indirect
        br_kind = 4'd4; acc = 8'hFF; dptr = 16'hFFF0; go("R6 ind wrap");
        acc = 8'h05; dptr = 16'h3000; go("R6 ind");
        // R7 conditionals, both outcomes
        cur_pc = 16'h4000; instr_len = 2'd2; rel_off = 8'hF0;
        br_kind = 4'd7; acc = 8'h00; go("R7 az true");
        acc = 8'h01; go("R7 az false");
        br_kind = 4'd8; go("R7 anz true");
        acc = 8'h00; go("R7 anz false");
        br_kind = 4'd9;  carry_in = 1'b1; go("R7 c true");
        br_kind = 4'd10; go("R7 nc false");
        carry_in = 1'b0; go("R7 nc true");
        br_kind = 4'd11; bit_in = 1'b0; go("R7 b false");
        bit_in = 1'b1; go("R7 b true");
        br_kind = 4'd12; go("R7 nb false");
        // R8 compare
        br_kind = 4'd13; instr_len = 2'd3;
        cmp_a = 8'h10; cmp_b = 8'h10; go("R8 cmp equal");
        cmp_a = 8'h0F; cmp_b = 8'hF0; go("R8 cmp less");
        cmp_a = 8'hF0; cmp_b = 8'h0F; go("R8 cmp greater");
        // R9 decrement
        br_kind = 4'd14; instr_len = 2'd2;
        dec_src = 8'h01; go("R9 dec to zero");
        dec_src = 8'h00; go("R9 dec wrap");
        dec_src = 8'h80; go("R9 dec mid");
        // R10 calls
        br_kind = 4'd5; cur_pc = 16'h12FE; instr_len = 2'd3; abs_addr = 16'h8000; go("R10 R3 long call");
        br_kind = 4'd6; cur_pc = 16'h37FF; instr_len = 2'd2; page_addr = 11'h055; go("R10 R4 page call");
        // back-to-back non-call requests
        br_kind = 4'd0; cur_pc = 16'h0000; instr_len = 2'd1;
        req_valid = 1'b1;
        @(negedge clk);
        cur_pc = 16'h0001;
        @(negedge clk);
        req_valid = 1'b0;
        chk(next_pc == 16'h0002, "R2 R11 back-to-back", int'(next_pc), 16'h0002);
        @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule